// File: doc/BRIEF.md
# Command Ring Fetch Controller

This block feeds an asynchronous DMA engine from a circular command ring held in memory. Software programs the ring base, the ring size (as a power of two in dwords), a read pointer and a write pointer through a small register port, then sets an enable bit. Whenever the engine is enabled and the two pointers differ, the controller reads the dword at the read pointer over a memory read port and presents it on a valid/ready output stream. The read pointer advances, wrapping at the ring size, each time the downstream side accepts a dword.

Software adds work by moving the write pointer forward. When the downstream packet decoder signals that a packet boundary has been consumed, the controller can post the current read pointer to a separately programmed, dword-aligned memory address, so software can poll progress without register reads. Packet decoding itself is left to the downstream logic.

Top module: `dma_ring_fetch`

## Requirements
- R1: After reset every register reads zero and `rd_req_valid`, `cmd_valid` and `wr_valid` are low.
- R2: Register index 0 is control (bit 0 enable, bits [5:1] log2 of ring size in dwords, bit 12 writeback enable); 1 is the ring base (memory address divided by 256); 2 and 3 are the read and write pointers as byte offsets in bits [17:2]; 4 is the writeback address low part in bits [31:2]; 5 is its high part in bits [7:0]. `reg_rdata` shows the addressed register the cycle after `reg_rd_en`, with all bits outside these fields reading zero.
- R3: A read request is raised only while enable is set and the read pointer differs from the write pointer; with enable clear no new request starts.
- R4: The request address is base*256 + read_index*4, and a request stays valid with an unchanged address until `rd_req_ready`.
- R5: Each response dword appears on `cmd_data` with `cmd_valid`, held unchanged until `cmd_ready`; the read pointer advances by one dword per accepted output.
- R6: The read pointer wraps to zero after the last dword of the ring (index 2^log2 - 1).
- R7: A write-pointer update is seen by the fetch logic on the cycle after the register write; with work pending, `rd_req_valid` rises one cycle after the write.
- R8: With writeback enabled, a `pkt_done` pulse posts a write to address {high, low[31:2], 2'b00} carrying the read pointer byte offset at that moment; the write is held until `wr_ready`, and a later `pkt_done` while it waits replaces the data.
- R9: With writeback disabled, `pkt_done` produces no memory write.
- R10: At most one dword is in flight: no new read is accepted until the previous dword has been taken downstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | 40 | Memory read byte address |
| rd_rsp_valid | input | 1 | Memory read data valid |
| rd_rsp_data | input | 32 | Memory read data |
| wr_valid | output | 1 | Pointer writeback valid |
| wr_ready | input | 1 | Pointer writeback accepted |
| wr_addr | output | 40 | Pointer writeback byte address |
| wr_data | output | 32 | Pointer writeback data (byte offset) |
| cmd_valid | output | 1 | Command dword valid |
| cmd_ready | input | 1 | Downstream accepts command dword |
| cmd_data | output | 32 | Command dword |
| pkt_done | input | 1 | Downstream finished a packet |

## Verification
The bench uses the default parameters (16-bit dword index, 8 high address bits, 256-byte base alignment) and programs a ring of log2 size 3, so eight dwords make the wrap at index 7 reachable within a handful of transfers. A maximal size field (31) is also written to show that values above the index width are stored and read back intact. Memory responses are computed from the request address, so a wrong fetch address appears as a data mismatch in the scoreboard, and stall patterns on the read and output handshakes exercise the hold rules.

// File: rtl/ring_fetch_pkg.sv
package ring_fetch_pkg;
  localparam int REG_AW        = 3;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SIZE_LSB = 1;
  localparam int CTRL_SIZE_W   = 5;
  localparam int CTRL_WB_BIT   = 12;

  typedef enum logic [REG_AW-1:0] {
    IDX_CTRL = 3'd0,
    IDX_BASE = 3'd1,
    IDX_RPTR = 3'd2,
    IDX_WPTR = 3'd3,
    IDX_WBLO = 3'd4,
    IDX_WBHI = 3'd5
  } reg_idx_e;

  typedef enum logic [1:0] {
    F_IDLE,
    F_REQ,
    F_WAIT,
    F_OUT
  } fetch_state_e;
endpackage

// File: rtl/ring_regs.sv
module ring_regs
  import ring_fetch_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 16,
  parameter int HI_W   = 8,
  parameter int BASE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              consume,
  output logic              en,
  output logic              wb_en,
  output logic [BASE_W-1:0] base,
  output logic [PTR_W-1:0]  rptr,
  output logic [PTR_W-1:0]  wptr,
  output logic [29:0]       wb_lo,
  output logic [HI_W-1:0]   wb_hi
);
  logic [CTRL_SIZE_W-1:0] size_log2;
  logic [PTR_W-1:0]       ring_mask;
  logic [DATA_W-1:0]      rd_mux;
  logic                   unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    for (int i = 0; i < PTR_W; i++)
      ring_mask[i] = (i < int'(size_log2));
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      IDX_CTRL: begin
        rd_mux[CTRL_EN_BIT] = en;
        rd_mux[CTRL_SIZE_LSB +: CTRL_SIZE_W] = size_log2;
        rd_mux[CTRL_WB_BIT] = wb_en;
      end
      IDX_BASE: rd_mux[BASE_W-1:0] = base;
      IDX_RPTR: rd_mux[PTR_W+1:0] = {rptr, 2'b00};
      IDX_WPTR: rd_mux[PTR_W+1:0] = {wptr, 2'b00};
      IDX_WBLO: rd_mux[31:0] = {wb_lo, 2'b00};
      IDX_WBHI: rd_mux[HI_W-1:0] = wb_hi;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      wb_en     <= 1'b0;
      size_log2 <= '0;
      base      <= '0;
      rptr      <= '0;
      wptr      <= '0;
      wb_lo     <= '0;
      wb_hi     <= '0;
      rdata     <= '0;
    end else begin
      if (consume)
        rptr <= (rptr + PTR_W'(1)) & ring_mask;
      if (wr_en) begin
        case (addr)
          IDX_CTRL: begin
            en        <= wdata[CTRL_EN_BIT];
            size_log2 <= wdata[CTRL_SIZE_LSB +: CTRL_SIZE_W];
            wb_en     <= wdata[CTRL_WB_BIT];
          end
          IDX_BASE: base  <= wdata[BASE_W-1:0];
          IDX_RPTR: rptr  <= wdata[PTR_W+1:2];
          IDX_WPTR: wptr  <= wdata[PTR_W+1:2];
          IDX_WBLO: wb_lo <= wdata[31:2];
          IDX_WBHI: wb_hi <= wdata[HI_W-1:0];
          default: ;
        endcase
      end
      if (rd_en)
        rdata <= rd_mux;
    end
  end

  // R6: an advance with no register write in the same cycle lands inside the ring
  a_r6_rptr_wraps: assert property (@(posedge clk) disable iff (rst)
    $past(consume && !wr_en) |-> ((rptr & ~ring_mask) == '0));
endmodule

// File: rtl/ring_fetch.sv
module ring_fetch
  import ring_fetch_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PTR_W      = 16,
  parameter int ADDR_W     = 40,
  parameter int BASE_SHIFT = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic [PTR_W-1:0]           rptr,
  input  logic [PTR_W-1:0]           wptr,
  input  logic [ADDR_W-BASE_SHIFT-1:0] ring_base,
  output logic                       rd_req_valid,
  input  logic                       rd_req_ready,
  output logic [ADDR_W-1:0]          rd_req_addr,
  input  logic                       rd_rsp_valid,
  input  logic [DATA_W-1:0]          rd_rsp_data,
  output logic                       cmd_valid,
  input  logic                       cmd_ready,
  output logic [DATA_W-1:0]          cmd_data,
  output logic                       consume
);
  fetch_state_e state;
  logic [ADDR_W-1:0] next_addr;
  logic              has_work;

  assign has_work  = en && (rptr != wptr);
  assign next_addr = {ring_base, {BASE_SHIFT{1'b0}}} + ADDR_W'({rptr, 2'b00});
  assign consume   = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= F_IDLE;
      rd_req_valid <= 1'b0;
      rd_req_addr  <= '0;
      cmd_valid    <= 1'b0;
      cmd_data     <= '0;
    end else begin
      case (state)
        F_IDLE: if (has_work) begin
          rd_req_valid <= 1'b1;
          rd_req_addr  <= next_addr;
          state        <= F_REQ;
        end
        F_REQ: if (rd_req_ready) begin
          rd_req_valid <= 1'b0;
          state        <= F_WAIT;
        end
        F_WAIT: if (rd_rsp_valid) begin
          cmd_valid <= 1'b1;
          cmd_data  <= rd_rsp_data;
          state     <= F_OUT;
        end
        default: if (cmd_ready) begin
          cmd_valid <= 1'b0;
          state     <= F_IDLE;
        end
      endcase
    end
  end

  // R3: a request starts only with enable set and work pending
  a_r3_req_needs_work: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req_valid) |-> $past(en && (rptr != wptr)));
  // R4: request held steady until accepted
  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
  // R5: output dword held steady until accepted
  a_r5_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));
endmodule

// File: rtl/rptr_writeback.sv
module rptr_writeback #(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 16,
  parameter int HI_W   = 8,
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_done,
  input  logic              wb_en,
  input  logic [PTR_W-1:0]  rptr,
  input  logic [29:0]       wb_lo,
  input  logic [HI_W-1:0]   wb_hi,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (pkt_done && wb_en) begin
      wr_valid <= 1'b1;
      wr_addr  <= {wb_hi, wb_lo, 2'b00};
      wr_data  <= DATA_W'({rptr, 2'b00});
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  // R8: a waiting write keeps address and data unless a new boundary arrives
  a_r8_wr_hold: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready && !pkt_done |=> wr_valid && $stable(wr_data) && $stable(wr_addr));
  // R9: a write only starts from a boundary with writeback enabled
  a_r9_wr_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |-> $past(pkt_done && wb_en));
endmodule

// File: rtl/dma_ring_fetch.sv
module dma_ring_fetch
  import ring_fetch_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PTR_W      = 16,
  parameter int HI_W       = 8,
  parameter int BASE_SHIFT = 8,
  localparam int ADDR_W    = 32 + HI_W,
  localparam int BASE_W    = ADDR_W - BASE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              pkt_done
);
  logic              en, wb_en, consume;
  logic [BASE_W-1:0] base;
  logic [PTR_W-1:0]  rptr, wptr;
  logic [29:0]       wb_lo;
  logic [HI_W-1:0]   wb_hi;

  ring_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W), .HI_W(HI_W), .BASE_W(BASE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .consume(consume), .en(en), .wb_en(wb_en),
    .base(base), .rptr(rptr), .wptr(wptr), .wb_lo(wb_lo), .wb_hi(wb_hi)
  );

  ring_fetch #(.DATA_W(DATA_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W), .BASE_SHIFT(BASE_SHIFT)) u_fetch (
    .clk(clk), .rst(rst), .en(en), .rptr(rptr), .wptr(wptr), .ring_base(base),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data), .consume(consume)
  );

  rptr_writeback #(.DATA_W(DATA_W), .PTR_W(PTR_W), .HI_W(HI_W), .ADDR_W(ADDR_W)) u_wb (
    .clk(clk), .rst(rst), .pkt_done(pkt_done), .wb_en(wb_en), .rptr(rptr),
    .wb_lo(wb_lo), .wb_hi(wb_hi), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: tb/tb_dma_ring_fetch.sv
module tb_dma_ring_fetch;
  import ring_fetch_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rd_req_valid, rd_req_ready = 1'b0;
  logic [39:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic        wr_valid, wr_ready = 1'b0;
  logic [39:0] wr_addr;
  logic [31:0] wr_data;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [31:0] cmd_data;
  logic        pkt_done = 1'b0;

  dma_ring_fetch dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .pkt_done(pkt_done)
  );

  always #4 clk = ~clk;

  localparam logic [39:0] RING_ADDR = 40'h00_1234_5000;
  localparam logic [39:0] WB_ADDR   = 40'hAB_8000_0010;

  int errors = 0, checks = 0, cycle = 0;
  int reqs = 0, wrs = 0, inflight = 0;
  bit r10_bad = 1'b0, rd_stall = 1'b0, cmd_stall = 1'b0, wr_hold = 1'b0;
  bit rsp_pend = 1'b0;
  logic [39:0] rsp_addr = '0;
  logic [31:0] exp_cmd[$];
  logic [71:0] exp_wr[$];

  function automatic logic [31:0] mem_word(input logic [39:0] a);
    return a[33:2] ^ 32'hC0DE_0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory, downstream and writeback models plus scoreboard monitor
  always @(negedge clk) begin
    cycle++;
    rd_rsp_valid = rsp_pend;
    rd_rsp_data  = rsp_pend ? mem_word(rsp_addr) : 32'h0;
    rsp_pend     = 1'b0;
    rd_req_ready = rd_stall ? cycle[0] : 1'b1;
    if (rd_req_valid && rd_req_ready) begin
      rsp_pend = 1'b1;
      rsp_addr = rd_req_addr;
      reqs++;
      if (inflight > 0) r10_bad = 1'b1;
      inflight++;
    end
    cmd_ready = cmd_stall ? ((cycle % 3) != 0) : 1'b1;
    if (cmd_valid && cmd_ready) begin
      inflight--;
      if (exp_cmd.size() == 0) check(1'b0, "R5 unexpected dword", 72'(cmd_data), 72'h0);
      else begin
        logic [31:0] e;
        e = exp_cmd.pop_front();
        check(cmd_data == e, "R4/R5 dword", 72'(cmd_data), 72'(e));
      end
    end
    wr_ready = !wr_hold;
    if (wr_valid && wr_ready) begin
      wrs++;
      if (exp_wr.size() == 0) check(1'b0, "R9 unexpected write", {wr_addr, wr_data}, 72'h0);
      else begin
        logic [71:0] e;
        e = exp_wr.pop_front();
        check({wr_addr, wr_data} == e, "R8 writeback", {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read_check(input logic [2:0] a, input logic [31:0] e, input string req);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    check(reg_rdata == e, req, 72'(reg_rdata), 72'(e));
  endtask

  task automatic push_range(input int first, input int count, input int ring);
    for (int k = 0; k < count; k++)
      exp_cmd.push_back(mem_word(RING_ADDR + 40'(((first + k) % ring) * 4)));
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((exp_cmd.size() != 0 || inflight != 0) && n < 3000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
    check(exp_cmd.size() == 0, req, 72'(exp_cmd.size()), 72'h0);
  endtask

  task automatic pulse_done();
    pkt_done = 1'b1;
    @(negedge clk);
    pkt_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!rd_req_valid && !cmd_valid && !wr_valid, "R1 outputs idle",
          72'({rd_req_valid, cmd_valid, wr_valid}), 72'h0);
    for (int i = 0; i < 6; i++) reg_read_check(3'(i), 32'h0, "R1 reset register");

    // R2 register map and field masking
    reg_write(IDX_CTRL, 32'hFFFF_FFFE);
    reg_read_check(IDX_CTRL, 32'h0000_103E, "R2 control fields");
    reg_write(IDX_CTRL, 32'h0000_0006);
    reg_write(IDX_BASE, 32'h0012_3450);
    reg_read_check(IDX_BASE, 32'h0012_3450, "R2 base");
    reg_write(IDX_RPTR, 32'hFFFF_FFFF);
    reg_read_check(IDX_RPTR, 32'h0003_FFFC, "R2 read pointer field");
    reg_write(IDX_WPTR, 32'hFFFF_FFFF);
    reg_read_check(IDX_WPTR, 32'h0003_FFFC, "R2 write pointer field");
    reg_write(IDX_RPTR, 32'h0);
    reg_write(IDX_WPTR, 32'h0);
    reg_write(IDX_WBLO, 32'h8000_0013);
    reg_read_check(IDX_WBLO, 32'h8000_0010, "R2 writeback low");
    reg_write(IDX_WBHI, 32'h0000_01AB);
    reg_read_check(IDX_WBHI, 32'h0000_00AB, "R2 writeback high");

    // R3 enabled but empty: no request
    reg_write(IDX_CTRL, 32'h0000_0007);
    repeat (10) @(negedge clk);
    check(reqs == 0, "R3 empty ring fetches nothing", 72'(reqs), 72'h0);

    // R7 new write pointer seen next cycle, then R4/R5 fetch of five dwords
    push_range(0, 5, 8);
    reg_write(IDX_WPTR, 32'd20);
    check(!rd_req_valid, "R7 no request in write cycle", 72'(rd_req_valid), 72'h0);
    @(negedge clk);
    check(rd_req_valid, "R7 request one cycle after write", 72'(rd_req_valid), 72'h1);
    drain("R5 first batch drained");
    reg_read_check(IDX_RPTR, 32'd20, "R5 read pointer advanced");

    // R6 wrap with stalls on both handshakes
    rd_stall = 1'b1; cmd_stall = 1'b1;
    push_range(5, 6, 8);
    reg_write(IDX_WPTR, 32'd12);
    drain("R6 wrap batch drained");
    reg_read_check(IDX_RPTR, 32'd12, "R6 read pointer wrapped");
    rd_stall = 1'b0; cmd_stall = 1'b0;

    // R3 disabled: pending work is not fetched
    reg_write(IDX_CTRL, 32'h0000_0006);
    r = reqs;
    reg_write(IDX_WPTR, 32'd28);
    repeat (20) @(negedge clk);
    check(reqs == r, "R3 disabled fetches nothing", 72'(reqs), 72'(r));
    reg_read_check(IDX_RPTR, 32'd12, "R3 read pointer held while disabled");
    push_range(3, 4, 8);
    reg_write(IDX_CTRL, 32'h0000_0007);
    drain("R3 resume after enable");
    reg_read_check(IDX_RPTR, 32'd28, "R5 read pointer after resume");

    // R8 writeback held, data replaced by later boundary
    reg_write(IDX_CTRL, 32'h0000_1006);
    wr_hold = 1'b1;
    pulse_done();
    repeat (4) @(negedge clk);
    check(wr_valid && wrs == 0, "R8 write held while not ready", 72'({wr_valid, 8'(wrs)}), 72'h100);
    check(wr_data == 32'd28, "R8 writeback data", 72'(wr_data), 72'd28);
    reg_write(IDX_RPTR, 32'd8);
    pulse_done();
    exp_wr.push_back({WB_ADDR, 32'd8});
    wr_hold = 1'b0;
    repeat (5) @(negedge clk);
    check(wrs == 1 && exp_wr.size() == 0, "R8 single replaced write", 72'(wrs), 72'h1);

    // R9 boundary with writeback disabled
    reg_write(IDX_CTRL, 32'h0000_0006);
    pulse_done();
    repeat (8) @(negedge clk);
    check(wrs == 1 && !wr_valid, "R9 no write when disabled", 72'({wr_valid, 8'(wrs)}), 72'h1);

    // R10 single outstanding read
    check(!r10_bad, "R10 one dword in flight", 72'(r10_bad), 72'h0);
    finish_run();
  end
endmodule